// File: doc/BRIEF.md
# Parallel Flash Programming Command Interface

This block is the target-side receiver for a parallel programming port on a chip with on-chip nonvolatile memory. An external programmer places a 4-bit command and, when needed, a data byte on the pins. It then pulls an active-low enable strobe low. The block acts once on each falling edge of that strobe, with the edge found synchronously on the block clock.

The supported operations are:
- whole-array erase
- byte program and byte read
- read and write of a 16-bit address register, one byte at a time

The top command bit selects the memory space: program (code) memory or data memory. The block holds the address register itself. After each byte program, the low address byte steps by one, so a run of sequential writes needs the address set only once.

Erase and program go to a small behavioural memory model through a request/done handshake. A busy flag is high for the whole operation, and strobes seen while it is high are dropped. On reads the block turns its side of the data bus to output. The pad tri-state is driven by `data_oe`.

Top module: `pp_cmd_if`

## Requirements
- R1: After reset, `busy` and `data_oe` are 0, both address bytes are 0x00, and every byte of both memory spaces reads 0xFF.
- R2: Command 1110 on a strobe writes `data_in` into the high address byte when `addr_sel`=1, or into the low address byte when `addr_sel`=0.
- R3: Command 0110 on a strobe sets `data_oe`=1 and presents the selected address byte on `data_out` (`addr_sel`=1 high, 0 low) by the first clock edge after the strobe is sampled.
- R4: Command x010 (x = `cmd[3]`, 1 = program memory, 0 = data memory) writes `data_in` at the current address of the selected space. `busy` is 1 from the strobe edge until the memory reports done.
- R5: Command x011 sets `data_oe`=1 and presents the byte at the current address of the space chosen by `cmd[3]`. Program memory uses the address modulo 64 and data memory the address modulo 16.
- R6: Each completed byte program adds one to the low address byte. 0xFF wraps to 0x00 and the high byte is left unchanged.
- R7: Command 0000 sets every byte of both spaces to 0xFF and holds `busy` until done.
- R8: A strobe that arrives while `busy`=1 has no effect: no address change, no memory change, and `data_oe` stays 0.
- R9: `data_oe` returns to 0 on the first clock edge at which `en_n` is sampled high. It is never set by a non-read command.
- R10: Command 1111 and the codes outside the list above change nothing and leave `data_oe` at 0.
- R11: Holding `en_n` low performs the command once; only a new falling edge starts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low command strobe |
| cmd | input | 4 | Command code; bit 3 is the memory-space select |
| addr_sel | input | 1 | Address byte select for address commands (1 high, 0 low) |
| data_in | input | 8 | Bus value driven by the programmer |
| data_out | output | 8 | Bus value driven by the block on reads |
| data_oe | output | 1 | Output enable for the bus pads |
| busy | output | 1 | Erase or program in progress |

## Verification
The assertions assume that `en_n` stays high while reset is active. They also assume the programmer holds `cmd`, `addr_sel` and `data_in` steady in the cycle where the strobe is first seen low. The bench changes those inputs only on the falling clock edge, together with the strobe. It releases the strobe at least one cycle before starting another command, except in the deliberate held-strobe and strobe-while-busy cases. Random commands come from a fixed seed and are drawn only from codes whose results a bench reference memory and address can predict.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [2:0] {
        K_NONE,
        K_ERASE,
        K_PROG,
        K_READ,
        K_RDADDR,
        K_WRADDR
    } pp_kind_e;

    localparam logic SPACE_CODE = 1'b1;
    localparam logic SPACE_DATA = 1'b0;
endpackage

// File: rtl/pp_cmd_decode.sv
module pp_cmd_decode
    import pp_pkg::*;
(
    input  logic [3:0] cmd,
    output pp_kind_e   kind,
    output logic       space
);
    always_comb begin
        space = cmd[3];
        unique casez (cmd)
            4'b0000: kind = K_ERASE;
            4'b?010: kind = K_PROG;
            4'b?011: kind = K_READ;
            4'b0110: kind = K_RDADDR;
            4'b1110: kind = K_WRADDR;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/pp_mem_model.sv
module pp_mem_model #(
    parameter int CODE_AW = 6,
    parameter int DATA_AW = 4,
    parameter int LAT     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        op_erase,
    input  logic        wr_space,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        rd_space,
    output logic [7:0]  rdata,
    output logic        done
);
    localparam int CODE_DEPTH = 1 << CODE_AW;
    localparam int DATA_DEPTH = 1 << DATA_AW;
    localparam int CW         = $clog2(LAT + 1);

    logic [7:0]    code_q [CODE_DEPTH];
    logic [7:0]    data_q [DATA_DEPTH];
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          unused_addr;

    assign unused_addr = ^addr[15:CODE_AW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_q[i] <= 8'hFF;
            for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= 8'hFF;
        end else if (req) begin
            if (op_erase) begin
                for (int i = 0; i < CODE_DEPTH; i++) code_q[i] <= 8'hFF;
                for (int i = 0; i < DATA_DEPTH; i++) data_q[i] <= 8'hFF;
            end else if (wr_space) begin
                code_q[addr[CODE_AW-1:0]] <= wdata;
            end else begin
                data_q[addr[DATA_AW-1:0]] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (cnt_q == CW'(1));
            if (req)               cnt_q <= CW'(LAT);
            else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
        end
    end

    assign rdata = rd_space ? code_q[addr[CODE_AW-1:0]] : data_q[addr[DATA_AW-1:0]];
    assign done  = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
endmodule

// File: rtl/pp_cmd_if.sv
module pp_cmd_if
    import pp_pkg::*;
#(
    parameter int CODE_AW = 6,
    parameter int DATA_AW = 4,
    parameter int LAT     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_n,
    input  logic [3:0] cmd,
    input  logic       addr_sel,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       busy
);
    typedef struct packed {
        logic       en_prev;
        logic       busy;
        logic       is_prog;
        logic       req;
        logic       req_erase;
        logic       wr_space;
        logic [7:0] wdata;
        logic       oe;
        logic [7:0] dout;
        logic [7:0] addr_hi;
        logic [7:0] addr_lo;
    } st_t;

    st_t      s_d, s_q;
    pp_kind_e kind;
    logic     space;
    logic     strobe;
    logic [7:0] mem_rdata;
    logic     mem_done;

    pp_cmd_decode u_dec (
        .cmd   (cmd),
        .kind  (kind),
        .space (space)
    );

    pp_mem_model #(
        .CODE_AW (CODE_AW),
        .DATA_AW (DATA_AW),
        .LAT     (LAT)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (s_q.req),
        .op_erase (s_q.req_erase),
        .wr_space (s_q.wr_space),
        .addr     ({s_q.addr_hi, s_q.addr_lo}),
        .wdata    (s_q.wdata),
        .rd_space (space),
        .rdata    (mem_rdata),
        .done     (mem_done)
    );

    assign strobe = s_q.en_prev && !en_n;

    always_comb begin
        s_d         = s_q;
        s_d.req     = 1'b0;
        s_d.en_prev = en_n;
        if (en_n) s_d.oe = 1'b0;
        if (mem_done) begin
            s_d.busy = 1'b0;
            if (s_q.is_prog) s_d.addr_lo = s_q.addr_lo + 8'd1;
        end
        if (strobe && !s_q.busy) begin
            unique case (kind)
                K_ERASE: begin
                    s_d.busy      = 1'b1;
                    s_d.req       = 1'b1;
                    s_d.req_erase = 1'b1;
                    s_d.is_prog   = 1'b0;
                end
                K_PROG: begin
                    s_d.busy      = 1'b1;
                    s_d.req       = 1'b1;
                    s_d.req_erase = 1'b0;
                    s_d.is_prog   = 1'b1;
                    s_d.wr_space  = space;
                    s_d.wdata     = data_in;
                end
                K_READ: begin
                    s_d.oe   = 1'b1;
                    s_d.dout = mem_rdata;
                end
                K_RDADDR: begin
                    s_d.oe   = 1'b1;
                    s_d.dout = addr_sel ? s_q.addr_hi : s_q.addr_lo;
                end
                K_WRADDR: begin
                    if (addr_sel) s_d.addr_hi = data_in;
                    else          s_d.addr_lo = data_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.en_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_out = s_q.dout;
    assign data_oe  = s_q.oe;
    assign busy     = s_q.busy;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !data_oe); // R9
    AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |-> !$past(s_q.busy)); // R8
    AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !busy); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_done |=> busy); // R4
    AST_HI_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |=> $stable(s_q.addr_hi)); // R6
endmodule

// File: tb/sim_pp_cmd_if.sv
module sim_pp_cmd_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic [3:0] cmd = 4'hF;
    logic       addr_sel = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] ref_code [64];
    logic [7:0] ref_data [16];
    logic [7:0] ref_hi, ref_lo;

    logic       got_oe, got_busy, got_oe_after;
    logic [7:0] got_q;

    always #2 clk = ~clk;

    pp_cmd_if u0 (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmd(cmd), .addr_sel(addr_sel),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mem(input logic sp);
        return sp ? ref_code[ref_lo[5:0]] : ref_data[ref_lo[3:0]];
    endfunction

    task automatic ref_erase();
        for (int i = 0; i < 64; i++) ref_code[i] = 8'hFF;
        for (int i = 0; i < 16; i++) ref_data[i] = 8'hFF;
    endtask

    task automatic pulse(input logic [3:0] c, input logic s, input logic [7:0] d);
        @(negedge clk);
        cmd = c; addr_sel = s; data_in = d; en_n = 1'b0;
        @(negedge clk);
        got_oe = data_oe; got_q = data_out; got_busy = busy;
        en_n = 1'b1; cmd = 4'hF;
        @(negedge clk);
        got_oe_after = data_oe;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        check("R4 busy clears", busy, 0);
    endtask

    task automatic do_wraddr(input logic s, input logic [7:0] d);
        pulse(4'b1110, s, d);
        if (s) ref_hi = d; else ref_lo = d;
        check("R9 no oe on addr write", got_oe, 0);
    endtask

    task automatic do_rdaddr(input logic s);
        pulse(4'b0110, s, 8'h00);
        check("R3 oe", got_oe, 1);
        check("R3 addr byte", got_q, s ? ref_hi : ref_lo);
        check("R9 oe released", got_oe_after, 0);
    endtask

    task automatic do_prog(input logic sp, input logic [7:0] d);
        pulse({sp, 3'b010}, 1'b0, d);
        check("R4 busy set", got_busy, 1);
        wait_idle();
        if (sp) ref_code[ref_lo[5:0]] = d; else ref_data[ref_lo[3:0]] = d;
        ref_lo = ref_lo + 8'd1;
    endtask

    task automatic do_read(input logic sp);
        pulse({sp, 3'b011}, 1'b0, 8'h00);
        check("R5 oe", got_oe, 1);
        check("R5 data", got_q, ref_mem(sp));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] bad [9];
        void'($urandom(32'd4242));
        bad = '{4'b0001, 4'b0100, 4'b0101, 4'b0111, 4'b1000,
                4'b1001, 4'b1100, 4'b1101, 4'b1111};
        ref_erase(); ref_hi = 0; ref_lo = 0;
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 oe", data_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_rdaddr(1'b1); // R1 reset address hi
        do_rdaddr(1'b0); // R1 reset address lo
        do_read(1'b1);   // R1 erased code
        do_read(1'b0);   // R1 erased data

        // R2 address write both bytes
        do_wraddr(1'b1, 8'h3C); do_wraddr(1'b0, 8'h05);
        do_rdaddr(1'b1); do_rdaddr(1'b0);

        // R4 R5 program/read both spaces, R6 sequential increment
        do_prog(1'b1, 8'hA5); do_prog(1'b1, 8'h5A);
        do_rdaddr(1'b0);
        do_wraddr(1'b0, 8'h05); do_read(1'b1);
        do_wraddr(1'b0, 8'h06); do_read(1'b1);
        do_prog(1'b0, 8'h77); do_wraddr(1'b0, 8'h06); do_read(1'b0);

        // R6 wrap without carry
        do_wraddr(1'b1, 8'h12); do_wraddr(1'b0, 8'hFF);
        do_prog(1'b1, 8'h99);
        do_rdaddr(1'b0); do_rdaddr(1'b1);

        // R8 strobes while busy ignored
        do_wraddr(1'b0, 8'h20);
        pulse(4'b1010, 1'b0, 8'h11);
        check("R4 busy after strobe", got_busy, 1);
        pulse(4'b1110, 1'b0, 8'h80);
        pulse(4'b1011, 1'b0, 8'h00);
        check("R8 no oe while busy", got_oe, 0);
        pulse(4'b1010, 1'b0, 8'h22);
        wait_idle();
        ref_code[6'h20] = 8'h11; ref_lo = 8'h21;
        do_rdaddr(1'b0);
        do_wraddr(1'b0, 8'h20); do_read(1'b1);

        // R11 strobe held low through the whole program
        @(negedge clk);
        cmd = 4'b0010; data_in = 8'h44; en_n = 1'b0;
        repeat (40) @(negedge clk);
        en_n = 1'b1; cmd = 4'hF;
        @(negedge clk);
        ref_data[ref_lo[3:0]] = 8'h44; ref_lo = ref_lo + 8'd1;
        check("R11 single action busy", busy, 0);
        do_rdaddr(1'b0);

        // R10 idle and undefined codes
        for (int i = 0; i < 9; i++) begin
            pulse(bad[i], 1'b0, 8'hEE);
            check("R10 no oe", got_oe, 0);
            check("R10 no busy", got_busy, 0);
        end
        do_rdaddr(1'b0); do_rdaddr(1'b1);

        // R7 erase
        pulse(4'b0000, 1'b0, 8'h00);
        check("R7 busy", got_busy, 1);
        wait_idle();
        ref_erase();
        do_read(1'b1); do_read(1'b0);
        do_wraddr(1'b0, 8'h06); do_read(1'b1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom % 7;
            case (k)
                0: do_wraddr($urandom % 2, 8'($urandom));
                1: do_rdaddr($urandom % 2);
                2, 3: do_prog($urandom % 2, 8'($urandom));
                4, 5: do_read($urandom % 2);
                default: begin
                    if ($urandom % 10 == 0) begin
                        pulse(4'b0000, 1'b0, 8'h00);
                        wait_idle();
                        ref_erase();
                    end else begin
                        pulse(bad[$urandom % 9], 1'b0, 8'($urandom));
                        check("R10 no oe random", got_oe, 0);
                    end
                end
            endcase
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule